// File: doc/BRIEF.md
# Boundary-Scan Instruction Register and Decoder

This block holds the 3-bit instruction of a boundary-scan test port and turns it into the controls the rest of the test logic needs. A shift stage collects a new instruction serially from TDI while the external state machine sits in Shift-IR. A separate latched stage presents the active instruction, which changes only on the falling test-clock edge of Update-IR, on Test-Logic-Reset, or on the asynchronous reset. Six instruction codes are recognised. The two unassigned codes act as BYPASS.

From the latched instruction the block derives three things: which data register sits in the scan path (boundary chain, 1-bit bypass or 32-bit identification), how device pins behave (functional, driven from boundary cells, or high impedance), and whether the boundary cells' output values are frozen. The block contains the identification and bypass registers. It merges the active serial source into one TDO flop that updates on the falling edge. The state machine and the boundary cells are external; the state machine supplies one strobe per relevant state.

Top module: `tap_instr_unit`

## Requirements
- R1: While rst_ni is low, and after any falling TCK edge with tlr_i high, instr_o is 001 (IDCODE). Test-Logic-Reset wins over a coincident Update-IR.
- R2: A rising TCK edge with cap_ir_i high loads 001 into the shift stage. Each rising edge with sh_ir_i high moves the stage one place toward TDO, entering TDI at bit 2, so bit 0 leaves first.
- R3: instr_o takes the shift-stage value only on a falling TCK edge with upd_ir_i high. Shifting or capturing without Update-IR leaves instr_o unchanged.
- R4: Exactly one data-register select is high. Codes 000 and 010 select the boundary chain, 001 selects identification, and 011, 100, 111, 101 and 110 select bypass.
- R5: pin_mode_o is 01 (boundary-driven) for codes 000 and 011, 10 (high impedance) for 100, and 00 (functional) for all other codes. hold_o is high only for 011.
- R6: With identification selected, a rising edge with cap_dr_i loads {version[3:0], part[15:0], maker[10:0], 1'b1}. Shift-DR then presents it on TDO LSB first.
- R7: With bypass selected, Capture-DR clears the bypass bit, and Shift-DR passes TDI to TDO with one stage of delay.
- R8: With the boundary chain selected, TDO in Shift-DR follows bsr_so_i.
- R9: tdo_o and tdo_en_o update on the falling TCK edge. tdo_en_o is high only after a falling edge in Shift-IR or Shift-DR. When tdo_en_o is low, tdo_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tdi_i | input | 1 | Serial test data in |
| tlr_i | input | 1 | State machine in Test-Logic-Reset |
| cap_ir_i | input | 1 | State machine in Capture-IR |
| sh_ir_i | input | 1 | State machine in Shift-IR |
| upd_ir_i | input | 1 | State machine in Update-IR |
| cap_dr_i | input | 1 | State machine in Capture-DR |
| sh_dr_i | input | 1 | State machine in Shift-DR |
| bsr_so_i | input | 1 | Serial output of the external boundary chain |
| instr_o | output | 3 | Latched active instruction |
| sel_bsr_o | output | 1 | Boundary chain selected |
| sel_byp_o | output | 1 | Bypass register selected |
| sel_id_o | output | 1 | Identification register selected |
| pin_mode_o | output | 2 | 00 functional, 01 boundary-driven, 10 high impedance |
| hold_o | output | 1 | Freeze boundary-cell output values |
| tdo_o | output | 1 | Serial test data out |
| tdo_en_o | output | 1 | TDO driver enable |

## Verification
Test-Logic-Reset and Update-IR can both be high at the same falling TCK edge. That edge decides whether the freshly shifted code or the forced IDCODE reaches instr_o. The bench first shifts a different code (HIGHZ) into the shift stage, then drives both strobes in one state. It checks that instr_o reads 001 and that the selects and pin mode are those of IDCODE. A second coincidence comes from the asynchronous reset arriving just after an EXTEST update. There the bench checks that instr_o and pin_mode_o return to their reset values before the next edge.

// File: rtl/tap_ir_pkg.sv
package tap_ir_pkg;
  localparam int unsigned IR_W = 3;

  localparam logic [IR_W-1:0] INS_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] INS_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] INS_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] INS_CLAMP  = 3'b011;
  localparam logic [IR_W-1:0] INS_HIGHZ  = 3'b100;
  localparam logic [IR_W-1:0] INS_BYPASS = 3'b111;

  // fixed capture pattern, low two bits read 01
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {
    PM_FUNC = 2'b00,
    PM_SCAN = 2'b01,
    PM_HIZ  = 2'b10
  } pin_mode_e;

  typedef struct packed {
    logic bsr;
    logic byp;
    logic id;
  } dr_sel_t;
endpackage

// File: rtl/tir_shift_latch.sv
module tir_shift_latch
  import tap_ir_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tdi_i,
  input  logic            tlr_i,
  input  logic            cap_i,
  input  logic            sh_i,
  input  logic            upd_i,
  output logic            sr_lsb_o,
  output logic [IR_W-1:0] instr_o
);
  logic [IR_W-1:0] sr_q;
  logic [IR_W-1:0] instr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= IR_CAPTURE;
    else if (cap_i) sr_q <= IR_CAPTURE;
    else if (sh_i)  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
  end

  // parallel stage updates on the falling edge; reset state wins
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)    instr_q <= INS_IDCODE;
    else if (tlr_i) instr_q <= INS_IDCODE;
    else if (upd_i) instr_q <= sr_q;
  end

  assign sr_lsb_o = sr_q[0];
  assign instr_o  = instr_q;

  // R2
  cap_pattern_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    cap_i |=> (sr_q == IR_CAPTURE));
  // R2
  ir_shift_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sh_i && !cap_i) |=> (sr_q[IR_W-1] == $past(tdi_i)));
  // R1
  tlr_forces_id_chk: assert property (@(negedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (instr_q == INS_IDCODE));
  // R3
  instr_hold_chk: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (!tlr_i && !upd_i) |=> $stable(instr_q));
endmodule

// File: rtl/tir_decode.sv
module tir_decode
  import tap_ir_pkg::*;
(
  input  logic [IR_W-1:0] instr_i,
  output dr_sel_t         sel_o,
  output pin_mode_e       pin_mode_o,
  output logic            hold_o
);
  always_comb begin
    sel_o      = '{bsr: 1'b0, byp: 1'b1, id: 1'b0};
    pin_mode_o = PM_FUNC;
    hold_o     = 1'b0;
    unique case (instr_i)
      INS_EXTEST: begin
        sel_o      = '{bsr: 1'b1, byp: 1'b0, id: 1'b0};
        pin_mode_o = PM_SCAN;
      end
      INS_IDCODE: sel_o = '{bsr: 1'b0, byp: 1'b0, id: 1'b1};
      INS_SAMPLE: sel_o = '{bsr: 1'b1, byp: 1'b0, id: 1'b0};
      INS_CLAMP: begin
        pin_mode_o = PM_SCAN;
        hold_o     = 1'b1;
      end
      INS_HIGHZ: pin_mode_o = PM_HIZ;
      default: ; // BYPASS and unassigned codes
    endcase
  end
endmodule

// File: rtl/tir_id_reg.sv
module tir_id_reg #(
  parameter int unsigned MFR_W = 11,
  parameter int unsigned PART_W = 16,
  parameter int unsigned VER_W = 4,
  parameter logic [MFR_W-1:0]  MFR_ID  = '0,
  parameter logic [PART_W-1:0] PART_ID = '0,
  parameter logic [VER_W-1:0]  VER_ID  = '0
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tdi_i,
  input  logic en_i,
  input  logic cap_i,
  input  logic sh_i,
  output logic so_o
);
  localparam int unsigned ID_W = 1 + MFR_W + PART_W + VER_W;
  localparam logic [ID_W-1:0] ID_VAL = {VER_ID, PART_ID, MFR_ID, 1'b1};

  logic [ID_W-1:0] q;

  for (genvar i = 0; i < ID_W; i++) begin : g_bit
    logic shin;
    if (i == ID_W - 1) begin : g_msb
      assign shin = tdi_i;
    end else begin : g_mid
      assign shin = q[i+1];
    end
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)             q[i] <= ID_VAL[i];
      else if (en_i && cap_i)  q[i] <= ID_VAL[i];
      else if (en_i && sh_i)   q[i] <= shin;
    end
  end

  assign so_o = q[0];

  // R6
  id_lsb_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (en_i && cap_i) |=> (so_o == 1'b1));
endmodule

// File: rtl/tir_bypass.sv
module tir_bypass (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tdi_i,
  input  logic en_i,
  input  logic cap_i,
  input  logic sh_i,
  output logic so_o
);
  logic q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)            q <= 1'b0;
    else if (en_i && cap_i) q <= 1'b0;
    else if (en_i && sh_i)  q <= tdi_i;
  end

  assign so_o = q;

  // R7
  byp_cap_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (en_i && cap_i) |=> !so_o);
  // R7
  byp_shift_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (en_i && sh_i && !cap_i) |=> (so_o == $past(tdi_i)));
endmodule

// File: rtl/tap_instr_unit.sv
module tap_instr_unit
  import tap_ir_pkg::*;
#(
  parameter int unsigned MFR_W = 11,
  parameter int unsigned PART_W = 16,
  parameter int unsigned VER_W = 4,
  parameter logic [MFR_W-1:0]  MFR_ID  = 11'h2B5,
  parameter logic [PART_W-1:0] PART_ID = 16'hC3E1,
  parameter logic [VER_W-1:0]  VER_ID  = 4'h9
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tdi_i,
  input  logic            tlr_i,
  input  logic            cap_ir_i,
  input  logic            sh_ir_i,
  input  logic            upd_ir_i,
  input  logic            cap_dr_i,
  input  logic            sh_dr_i,
  input  logic            bsr_so_i,
  output logic [IR_W-1:0] instr_o,
  output logic            sel_bsr_o,
  output logic            sel_byp_o,
  output logic            sel_id_o,
  output logic [1:0]      pin_mode_o,
  output logic            hold_o,
  output logic            tdo_o,
  output logic            tdo_en_o
);
  logic            ir_so;
  logic            id_so;
  logic            byp_so;
  logic [IR_W-1:0] instr;
  dr_sel_t         sel;
  pin_mode_e       pmode;
  logic            hold;
  logic            ser_nxt;
  logic            shift_any;
  logic            tdo_q;
  logic            tdo_en_q;

  tir_shift_latch u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tdi_i    (tdi_i),
    .tlr_i    (tlr_i),
    .cap_i    (cap_ir_i),
    .sh_i     (sh_ir_i),
    .upd_i    (upd_ir_i),
    .sr_lsb_o (ir_so),
    .instr_o  (instr)
  );

  tir_decode u_dec (
    .instr_i    (instr),
    .sel_o      (sel),
    .pin_mode_o (pmode),
    .hold_o     (hold)
  );

  tir_id_reg #(
    .MFR_W  (MFR_W),
    .PART_W (PART_W),
    .VER_W  (VER_W),
    .MFR_ID (MFR_ID),
    .PART_ID(PART_ID),
    .VER_ID (VER_ID)
  ) u_id (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tdi_i  (tdi_i),
    .en_i   (sel.id),
    .cap_i  (cap_dr_i),
    .sh_i   (sh_dr_i),
    .so_o   (id_so)
  );

  tir_bypass u_byp (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tdi_i  (tdi_i),
    .en_i   (sel.byp),
    .cap_i  (cap_dr_i),
    .sh_i   (sh_dr_i),
    .so_o   (byp_so)
  );

  assign shift_any = sh_ir_i | sh_dr_i;

  always_comb begin
    if (sh_ir_i)      ser_nxt = ir_so;
    else if (sel.bsr) ser_nxt = bsr_so_i;
    else if (sel.id)  ser_nxt = id_so;
    else              ser_nxt = byp_so;
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= shift_any ? ser_nxt : 1'b0;
      tdo_en_q <= shift_any;
    end
  end

  assign instr_o    = instr;
  assign sel_bsr_o  = sel.bsr;
  assign sel_byp_o  = sel.byp;
  assign sel_id_o   = sel.id;
  assign pin_mode_o = pmode;
  assign hold_o     = hold;
  assign tdo_o      = tdo_q;
  assign tdo_en_o   = tdo_en_q;

  // R4
  one_sel_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $countones({sel_bsr_o, sel_byp_o, sel_id_o}) == 1);
  // R5
  clamp_drive_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    hold_o |-> (pin_mode_o == PM_SCAN && sel_byp_o));
  // R5
  hiz_byp_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (pin_mode_o == PM_HIZ) |-> sel_byp_o);
  // R9
  tdo_off_chk: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !shift_any |=> (!tdo_en_o && !tdo_o));
  // R9
  tdo_on_chk: assert property (@(negedge tck_i) disable iff (!rst_ni)
    shift_any |=> tdo_en_o);
endmodule

// File: tb/tap_instr_unit_tb.sv
module tap_instr_unit_tb;
  localparam logic [10:0] T_MFR  = 11'h2B5;
  localparam logic [15:0] T_PART = 16'hC3E1;
  localparam logic [3:0]  T_VER  = 4'h9;
  localparam logic [31:0] EXP_ID = {T_VER, T_PART, T_MFR, 1'b1};

  localparam logic [5:0] S_IDLE = 6'b000000;
  localparam logic [5:0] S_TLR  = 6'b100000;
  localparam logic [5:0] S_CIR  = 6'b010000;
  localparam logic [5:0] S_SIR  = 6'b001000;
  localparam logic [5:0] S_UIR  = 6'b000100;
  localparam logic [5:0] S_CDR  = 6'b000010;
  localparam logic [5:0] S_SDR  = 6'b000001;

  logic tck = 1'b0;
  logic rst_ni = 1'b1;
  logic tdi = 1'b0;
  logic tlr = 1'b0, cap_ir = 1'b0, sh_ir = 1'b0, upd_ir = 1'b0;
  logic cap_dr = 1'b0, sh_dr = 1'b0;
  logic bsr_so = 1'b0;
  logic [2:0] instr;
  logic sel_bsr, sel_byp, sel_id, hold, tdo, tdo_en;
  logic [1:0] pin_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 tck = ~tck;

  tap_instr_unit #(
    .MFR_ID (T_MFR),
    .PART_ID(T_PART),
    .VER_ID (T_VER)
  ) u_dut (
    .tck_i     (tck),
    .rst_ni    (rst_ni),
    .tdi_i     (tdi),
    .tlr_i     (tlr),
    .cap_ir_i  (cap_ir),
    .sh_ir_i   (sh_ir),
    .upd_ir_i  (upd_ir),
    .cap_dr_i  (cap_dr),
    .sh_dr_i   (sh_dr),
    .bsr_so_i  (bsr_so),
    .instr_o   (instr),
    .sel_bsr_o (sel_bsr),
    .sel_byp_o (sel_byp),
    .sel_id_o  (sel_id),
    .pin_mode_o(pin_mode),
    .hold_o    (hold),
    .tdo_o     (tdo),
    .tdo_en_o  (tdo_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one TAP state: drive at posedge+1, sample after the falling edge
  task automatic tick(input logic [5:0] st, input logic d, input logic b,
                      output logic to, output logic toe);
    {tlr, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr} = st;
    tdi = d;
    bsr_so = b;
    @(negedge tck);
    #1;
    to = tdo;
    toe = tdo_en;
    @(posedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [2:0] code, input bit do_upd);
    logic to, toe;
    logic [2:0] cap_exp = 3'b001;
    tick(S_CIR, 1'b0, 1'b0, to, toe);
    for (int i = 0; i < 3; i++) begin
      tick(S_SIR, code[i], 1'b0, to, toe);
      chk("R2 capture bit out", {31'd0, to}, {31'd0, cap_exp[i]});
      chk("R9 enable in Shift-IR", {31'd0, toe}, 32'd1);
    end
    if (do_upd) tick(S_UIR, 1'b0, 1'b0, to, toe);
    else        tick(S_IDLE, 1'b0, 1'b0, to, toe);
    chk("R9 disabled outside shift", {30'd0, toe, to}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset instr", {29'd0, instr}, 32'h1);
    chk("R4 reset select id", {29'd0, sel_bsr, sel_byp, sel_id}, 32'h1);
    chk("R5 reset pin mode", {29'd0, hold, pin_mode}, 32'h0);
    chk("R9 reset tdo", {30'd0, tdo_en, tdo}, 32'h0);
  endtask

  task automatic t_decode_all;
    for (int c = 0; c < 8; c++) begin
      logic [2:0] exp_sel;
      logic [1:0] exp_pm;
      logic exp_hold;
      load_ir(c[2:0], 1'b1);
      chk("R3 update latches", {29'd0, instr}, c);
      case (c)
        0: begin exp_sel = 3'b100; exp_pm = 2'b01; exp_hold = 0; end
        1: begin exp_sel = 3'b001; exp_pm = 2'b00; exp_hold = 0; end
        2: begin exp_sel = 3'b100; exp_pm = 2'b00; exp_hold = 0; end
        3: begin exp_sel = 3'b010; exp_pm = 2'b01; exp_hold = 1; end
        4: begin exp_sel = 3'b010; exp_pm = 2'b10; exp_hold = 0; end
        default: begin exp_sel = 3'b010; exp_pm = 2'b00; exp_hold = 0; end
      endcase
      chk("R4 select", {29'd0, sel_bsr, sel_byp, sel_id}, {29'd0, exp_sel});
      chk("R5 pin mode", {30'd0, pin_mode}, {30'd0, exp_pm});
      chk("R5 hold", {31'd0, hold}, {31'd0, exp_hold});
    end
  endtask

  task automatic t_no_update;
    load_ir(3'b000, 1'b1);
    load_ir(3'b100, 1'b0);
    chk("R3 no update keeps instr", {29'd0, instr}, 32'h0);
    tick(S_CDR, 1'b0, 1'b0, tdo, tdo_en);
    chk("R3 capture-DR keeps instr", {29'd0, instr}, 32'h0);
  endtask

  task automatic t_idcode;
    logic to, toe;
    logic [31:0] got;
    load_ir(3'b001, 1'b1);
    tick(S_CDR, 1'b0, 1'b0, to, toe);
    got = '0;
    for (int i = 0; i < 32; i++) begin
      tick(S_SDR, i[0], 1'b0, to, toe);
      got[i] = to;
    end
    chk("R6 id value", got, EXP_ID);
    tick(S_SDR, 1'b0, 1'b0, to, toe);
    chk("R6 shifted-in bit 0 emerges", {31'd0, to}, 32'd0);
  endtask

  task automatic t_bypass(input logic [2:0] code);
    logic to, toe;
    logic [7:0] pat = 8'b1011_0110;
    load_ir(code, 1'b1);
    tick(S_CDR, 1'b1, 1'b0, to, toe);
    for (int k = 0; k < 8; k++) begin
      tick(S_SDR, pat[k], 1'b1, to, toe);
      if (k == 0) chk("R7 bypass captures 0", {31'd0, to}, 32'd0);
      else        chk("R7 bypass delay", {31'd0, to}, {31'd0, pat[k-1]});
    end
  endtask

  task automatic t_bsr;
    logic to, toe;
    logic [5:0] pat = 6'b110010;
    load_ir(3'b010, 1'b1);
    for (int k = 0; k < 6; k++) begin
      tick(S_SDR, ~pat[k], pat[k], to, toe);
      chk("R8 chain to tdo", {30'd0, toe, to}, {30'd0, 1'b1, pat[k]});
    end
    tick(S_IDLE, 1'b0, 1'b1, to, toe);
    chk("R9 tdo low when disabled", {30'd0, toe, to}, 32'd0);
  endtask

  task automatic t_tlr_vs_update;
    logic to, toe;
    load_ir(3'b000, 1'b1);
    tick(S_TLR, 1'b0, 1'b0, to, toe);
    chk("R1 tlr forces idcode", {29'd0, instr}, 32'h1);
    load_ir(3'b100, 1'b0);
    tick(S_TLR | S_UIR, 1'b0, 1'b0, to, toe);
    chk("R1 tlr beats update", {29'd0, instr}, 32'h1);
    chk("R1 selects after tlr", {29'd0, sel_bsr, sel_byp, sel_id}, 32'h1);
    chk("R1 pin mode after tlr", {30'd0, pin_mode}, 32'h0);
  endtask

  task automatic t_async_reset;
    load_ir(3'b000, 1'b1);
    chk("R1 pre-reset extest", {30'd0, pin_mode}, 32'h1);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset instr", {29'd0, instr}, 32'h1);
    chk("R1 async reset pin mode", {30'd0, pin_mode}, 32'h0);
    #1;
    rst_ni = 1'b1;
    @(posedge tck);
    #1;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    #20;
    t_reset();
    @(posedge tck);
    #1 rst_ni = 1'b1;
    @(posedge tck);
    #1;
    t_decode_all();
    t_no_update();
    t_idcode();
    t_bypass(3'b111);
    t_bypass(3'b101);
    t_bsr();
    t_tlr_vs_update();
    t_async_reset();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule